// File: doc/BRIEF.md
# System Bus Write Issue Controller

This controller takes processor writes from a request queue and places them on a shared address/data system bus. Each write takes two bus beats, an address beat followed by a data beat. The bus valid strobe is active low and is driven in both beats. An external agent gates the traffic with an active-low write-ready line. A write may start only when that line was asserted two cycles before the address beat. The line is checked again during the address beat itself to decide whether the agent took the write.

One mode input picks one of two behaviours. In reissue mode, a write that the agent did not take stays at the head of the queue and is driven again later. In pipelined mode, the agent may take one more write after write-ready drops. The write after that falls back to the reissue rule. The queue entry is popped only in the address beat of a write that was taken. The requester must therefore hold the head entry stable until that happens.

Top module: `bus_write_issuer`

## Requirements
- R1: While reset is held and after it with an empty queue, `bus_valid_n` is 1, `bus_cmd` is 2'b00 and `req_ready` is 0.
- R2: A write shows on the bus as an address beat (`bus_cmd` 2'b10, `bus_ad` = address) and then, in the next cycle, a data beat (`bus_cmd` 2'b01, `bus_ad` = data). `bus_valid_n` is 0 in both beats and 1 whenever `bus_cmd` is 2'b00.
- R3: While write-ready stays asserted and the queue holds writes, address beats follow each other every two cycles.
- R4: An address beat happens only if `wr_rdy_n` was 0 two cycles earlier. After write-ready returns in cycle r, the first address beat is in cycle r+2.
- R5: `req_ready` is 1 only during the address beat of a write that the agent takes. The head entry stays in place otherwise.
- R6: In reissue mode (`mode_pipe` = 0), a write whose address beat sees `wr_rdy_n` = 1 is not acknowledged. The same address and data are driven again at the next allowed issue.
- R7: In pipelined mode (`mode_pipe` = 1), one write whose address beat sees `wr_rdy_n` = 1 is still taken. A later such write is reissued until a write has been taken with write-ready asserted.
- R8: `mode_pipe` is sampled only in idle cycles. A change during a burst has no effect on that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_pipe | input | 1 | 0 = reissue mode, 1 = pipelined mode |
| req_valid | input | 1 | Queue head holds a write |
| req_addr | input | W | Address of the queue head |
| req_data | input | W | Data of the queue head |
| req_ready | output | 1 | Pop strobe: head write was taken |
| wr_rdy_n | input | 1 | Active-low write-ready from the external agent |
| bus_valid_n | output | 1 | Active-low strobe for a driven bus beat |
| bus_cmd | output | 2 | Beat type: 00 idle, 10 address, 01 data |
| bus_ad | output | W | Multiplexed address/data word |

## Verification
The assertions assume that `wr_rdy_n` is a clean level in every cycle after reset. They also assume the requester holds `req_addr` and `req_data` stable from the cycle `req_valid` rises until the cycle after the `req_ready` pulse. The stimulus changes write-ready and pops the queue only at the falling clock edge. The pop is applied half a cycle after the rising edge that follows the acknowledge, so the data beat still sees the entry that was taken. The write-ready patterns are chosen so that every drop lands on an address beat or on the issue check two cycles before one.

// File: rtl/bus_write_issuer.sv
module bus_write_issuer #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode_pipe,
  input  logic         req_valid,
  input  logic [W-1:0] req_addr,
  input  logic [W-1:0] req_data,
  output logic         req_ready,
  input  logic         wr_rdy_n,
  output logic         bus_valid_n,
  output logic [1:0]   bus_cmd,
  output logic [W-1:0] bus_ad
);

  localparam logic [1:0] CMD_IDLE = 2'b00;
  localparam logic [1:0] CMD_ADDR = 2'b10;
  localparam logic [1:0] CMD_DATA = 2'b01;

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA} state_t;

  state_t state;
  logic   rdy_d1;
  logic   mode_q;
  logic   spare;

  wire rdy_now = !wr_rdy_n;
  wire start   = req_valid && rdy_d1 && (state != S_ADDR);
  wire accept  = (state == S_ADDR) && (rdy_now || (mode_q && spare));

  assign req_ready = accept;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      rdy_d1      <= 1'b0;
      mode_q      <= 1'b0;
      spare       <= 1'b1;
      bus_valid_n <= 1'b1;
      bus_cmd     <= CMD_IDLE;
      bus_ad      <= '0;
    end else begin
      rdy_d1 <= rdy_now;
      if (state == S_IDLE)
        mode_q <= mode_pipe;
      if (state == S_ADDR) begin
        if (rdy_now)     spare <= 1'b1;
        else if (accept) spare <= 1'b0;
      end
      if (state == S_ADDR) begin
        state       <= S_DATA;
        bus_cmd     <= CMD_DATA;
        bus_ad      <= req_data;
        bus_valid_n <= 1'b0;
      end else if (start) begin
        state       <= S_ADDR;
        bus_cmd     <= CMD_ADDR;
        bus_ad      <= req_addr;
        bus_valid_n <= 1'b0;
      end else begin
        state       <= S_IDLE;
        bus_cmd     <= CMD_IDLE;
        bus_ad      <= '0;
        bus_valid_n <= 1'b1;
      end
    end
  end

  assert_data_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd == CMD_ADDR) |=> (bus_cmd == CMD_DATA && !bus_valid_n));

  assert_idle_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd == CMD_IDLE) |-> bus_valid_n);

  assert_ready_history_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd == CMD_ADDR) |-> $past(!wr_rdy_n, 2));

  assert_ack_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (bus_cmd == CMD_ADDR && !bus_valid_n));

  assert_reissue_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !mode_q) |-> !wr_rdy_n);

  assert_extra_only_piped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && wr_rdy_n) |-> mode_q);

  assert_mode_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd != CMD_IDLE) |=> $stable(mode_q));

endmodule

// File: tb/sim_bus_write_issuer.sv
module sim_bus_write_issuer;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_pipe = 1'b0;
  logic wr_rdy_n = 1'b1;
  logic [W-1:0] wa [0:63];
  logic [W-1:0] wd [0:63];
  int head = 0, tail = 0, cyc = 0, checks = 0, errors = 0, acks = 0;
  int lo_a = -10, hi_a = -10, lo_b = -10;
  bit pend = 1'b0;
  string cur_req = "R2";
  logic [1:0]   exp_cmd [$];
  logic [W-1:0] exp_ad  [$];
  int addr_cyc [$];

  wire          req_valid = (head != tail);
  wire [W-1:0]  req_addr  = wa[head[5:0]];
  wire [W-1:0]  req_data  = wd[head[5:0]];
  logic         req_ready, bus_valid_n;
  logic [1:0]   bus_cmd;
  logic [W-1:0] bus_ad;

  bus_write_issuer #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_pipe(mode_pipe),
    .req_valid(req_valid), .req_addr(req_addr), .req_data(req_data),
    .req_ready(req_ready), .wr_rdy_n(wr_rdy_n),
    .bus_valid_n(bus_valid_n), .bus_cmd(bus_cmd), .bus_ad(bus_ad)
  );

  initial forever #5 clk = ~clk;

  task automatic check(bit ok, string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit rdy_at(int c);
    return !((c >= lo_a && c <= hi_a) || c == lo_b);
  endfunction

  task automatic push_write(logic [W-1:0] a, logic [W-1:0] d);
    wa[tail[5:0]] = a;
    wd[tail[5:0]] = d;
    tail++;
  endtask

  task automatic expect_write(int i);
    exp_cmd.push_back(2'b10); exp_ad.push_back(wa[i]);
    exp_cmd.push_back(2'b01); exp_ad.push_back(wd[i]);
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic begin_scn(string req);
    cur_req = req;
    acks = 0;
    addr_cyc.delete();
  endtask

  task automatic end_scn(int acks_exp);
    settle(20);
    check(exp_cmd.size() == 0, cur_req, "beats missing", exp_cmd.size(), 0);
    check(acks == acks_exp, cur_req, "acknowledges", acks, acks_exp);
  endtask

  task automatic check_addr(int k, int c);
    if (addr_cyc.size() > k)
      check(addr_cyc[k] == c, cur_req, $sformatf("address beat %0d cycle", k), addr_cyc[k], c);
    else
      check(1'b0, cur_req, $sformatf("address beat %0d missing", k), addr_cyc.size(), k + 1);
  endtask

  // driver of write-ready and queue pops, plus bus monitor
  initial forever begin
    @(negedge clk);
    cyc++;
    if (pend) head++;
    wr_rdy_n = !rdy_at(cyc);
    #1;
    pend = req_valid && req_ready;
    if (pend) acks++;
    if (!bus_valid_n) begin
      if (exp_cmd.size() == 0)
        check(1'b0, cur_req, "unexpected beat", bus_ad, '0);
      else begin
        logic [1:0]   c;
        logic [W-1:0] a;
        c = exp_cmd.pop_front();
        a = exp_ad.pop_front();
        check(bus_cmd == c, cur_req, "beat type", bus_cmd, c);
        check(bus_ad == a, cur_req, "beat word", bus_ad, a);
      end
      if (bus_cmd == 2'b10) addr_cyc.push_back(cyc);
    end
  end

  initial begin
    #500000;
    errors++;
    $display("FAIL R1 watchdog actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int s;
    settle(3);
    check(bus_valid_n == 1'b1, "R1", "strobe in reset", bus_valid_n, 1);
    check(bus_cmd == 2'b00, "R1", "cmd in reset", bus_cmd, 0);
    check(req_ready == 1'b0, "R1", "ack in reset", req_ready, 0);
    rst_n = 1'b1;
    settle(6);
    check(bus_valid_n == 1'b1 && bus_cmd == 2'b00, "R1", "idle after reset", bus_cmd, 0);

    // R3: steady ready, back-to-back writes
    begin_scn("R3");
    s = cyc;
    for (int k = 0; k < 3; k++) begin
      push_write(32'h1000_0000 + k * 16, 32'hA5A5_0000 + k);
      expect_write(tail - 1);
    end
    end_scn(3);
    check_addr(0, s + 1); check_addr(1, s + 3); check_addr(2, s + 5);

    // R6: reissue mode, ready drops on the second address beat
    begin_scn("R6");
    s = cyc;
    lo_a = s + 3; hi_a = s + 3; lo_b = -10;
    push_write(32'h2000_0040, 32'h0BAD_0001); expect_write(tail - 1);
    push_write(32'h2000_0080, 32'h0BAD_0002); expect_write(tail - 1); expect_write(tail - 1);
    end_scn(2);
    check_addr(0, s + 1); check_addr(1, s + 3); check_addr(2, s + 6);

    // R8: mode change during a burst is ignored
    begin_scn("R8");
    s = cyc;
    lo_a = s + 3; hi_a = s + 3; lo_b = -10;
    push_write(32'h3000_0010, 32'h7777_0001); expect_write(tail - 1);
    push_write(32'h3000_0020, 32'h7777_0002); expect_write(tail - 1); expect_write(tail - 1);
    settle(2);
    mode_pipe = 1'b1;
    end_scn(2);
    check_addr(1, s + 3); check_addr(2, s + 6);

    // R7: pipelined mode, one extra write taken, the next reissued
    begin_scn("R7");
    s = cyc;
    lo_a = s + 3; hi_a = s + 3; lo_b = s + 6;
    push_write(32'h4000_0100, 32'hCAFE_0001); expect_write(tail - 1);
    push_write(32'h4000_0200, 32'hCAFE_0002); expect_write(tail - 1);
    push_write(32'h4000_0300, 32'hCAFE_0003); expect_write(tail - 1); expect_write(tail - 1);
    end_scn(3);
    check_addr(0, s + 1); check_addr(1, s + 3); check_addr(2, s + 6); check_addr(3, s + 9);

    // R6 with R5: back in reissue mode, same drop pattern
    mode_pipe = 1'b0;
    settle(3);
    begin_scn("R5");
    s = cyc;
    lo_a = s + 3; hi_a = s + 3; lo_b = -10;
    push_write(32'h5000_0004, 32'h1234_0001); expect_write(tail - 1);
    push_write(32'h5000_0008, 32'h1234_0002); expect_write(tail - 1); expect_write(tail - 1);
    push_write(32'h5000_000C, 32'h1234_0003); expect_write(tail - 1);
    end_scn(3);
    check_addr(1, s + 3); check_addr(2, s + 6); check_addr(3, s + 8);

    // R4: write waits for ready two cycles back
    begin_scn("R4");
    s = cyc;
    lo_a = s + 1; hi_a = s + 6; lo_b = -10;
    settle(3);
    push_write(32'h6000_0000, 32'hFEED_0001); expect_write(tail - 1);
    end_scn(1);
    check_addr(0, s + 9);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule